// File: doc/BRIEF.md
# I2C Event Interrupt and Vector Unit

This unit gathers the seven event flags of an I2C controller into one status word and gates them with a per-event enable mask. It drives a single registered interrupt line, which is high when any enabled flag is pending. It also answers reads of a vector register with a small code that names the most urgent pending enabled event. The protocol engine reports each event with a one-cycle set pulse. The level signals for receive-shift-full and bus-busy arrive as inputs and show up in the status word.

Software uses a 16-bit register port with a one-cycle read or write strobe and a combinational read data path. A typical handler reads the vector register until it reads zero. Each vector read retires the event it reports. The two data-flow events are the exception: they stay pending until the receive data offset is read or the transmit data offset is written. Two completion events can also be retired by writing ones to the status word.

Top module: `i2c_event_intc`

## Requirements
- R1: After a synchronous active-high reset, the mask word, every event flag, the vector code and the interrupt line are all zero.
- R2: A one-cycle pulse on ev_set[i] makes flag i pending from the next cycle on. The status word at offset 0x08 shows flag i at bit i, with arbitration lost at 0, NACK at 1, access ready at 2, receive ready at 3, transmit ready at 4, stop seen at 5 and addressed-as-slave at 6. Bit 11 shows rx_full_in and bit 12 shows bus_busy_in. All other bits read 0.
- R3: The mask word at offset 0x04 is written from reg_wdata[6:0], with the enable for event i at bit i. It reads back in bits 6:0, and bits 15:7 read 0.
- R4: A read at offset 0x28 returns in bits 2:0 the code i+1 of the lowest-numbered event that is both pending and enabled. It returns 0 when no such event exists, so pending events that are disabled never appear.
- R5: A vector read that returns 1, 2, 3, 6 or 7 clears the flag it reports from the next cycle on. No other flag changes.
- R6: A vector read that returns 4 (receive ready) or 5 (transmit ready) leaves that flag pending. The receive ready flag clears only on a read at offset 0x18, and the transmit ready flag clears only on a write at offset 0x20.
- R7: Writing a 1 to status bit 2 or bit 5 clears that flag. Writing 0 to those bits has no effect. Ones written to any other status bit are ignored.
- R8: If a set pulse for an event lands in the same cycle as any clear of that event, the flag is pending afterwards.
- R9: The irq output equals, one cycle later, the OR over all events of the flag ANDed with its mask bit.
- R10: A read at any offset other than 0x04, 0x08 and 0x28 returns 0. A write at any offset other than 0x04, 0x08 and 0x20 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Byte offset of the access |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the cycle of reg_rd |
| ev_set | input | 7 | Per-event set pulses from the protocol engine |
| rx_full_in | input | 1 | Receive shift register full level |
| bus_busy_in | input | 1 | Bus busy level |
| irq | output | 1 | Registered interrupt request |

## Verification
A corrupted flag or mask bit shows up in three places. It appears at once in the status or mask read-back. It appears in the vector code on the next vector read. It appears on irq one cycle after the bad value is stored. Clearing the wrong event shows up two ways: either the vector code fails to advance on the following read, or a later code is skipped. The bench compares irq every cycle and every read word against a behavioural model. A divergence is therefore reported in the cycle it first becomes visible at a port.

// File: rtl/i2cev_pkg.sv
package i2cev_pkg;

    localparam int EV_N   = 7;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 6;
    localparam int CODE_W = $clog2(EV_N + 1);

    typedef logic [EV_N-1:0]   ev_vec_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // event indices: the index is also the mask/status bit and fixes priority
    localparam int EV_ARB   = 0;
    localparam int EV_NACK  = 1;
    localparam int EV_ARDY  = 2;
    localparam int EV_RXRDY = 3;
    localparam int EV_TXRDY = 4;
    localparam int EV_STOP  = 5;
    localparam int EV_SLV   = 6;

    localparam addr_t OFS_MASK = 6'h04;
    localparam addr_t OFS_STAT = 6'h08;
    localparam addr_t OFS_RXD  = 6'h18;
    localparam addr_t OFS_TXD  = 6'h20;
    localparam addr_t OFS_VEC  = 6'h28;

    localparam int BIT_RXFULL = 11;
    localparam int BIT_BUSY   = 12;

    typedef enum logic [1:0] {
        RSEL_NONE,
        RSEL_MASK,
        RSEL_STAT,
        RSEL_VEC
    } rsel_t;

    typedef struct packed {
        logic mask_wr;
        logic stat_wr;
        logic vec_rd;
        logic rxd_rd;
        logic txd_wr;
    } access_t;

    function automatic ev_vec_t bit_of(input int idx);
        return ev_vec_t'(1) << idx;
    endfunction

    function automatic code_t idx_to_code(input int idx);
        return code_t'(idx + 1);
    endfunction

    // flags that a status write of one may retire
    localparam ev_vec_t W1C_SEL  = ev_vec_t'((1 << EV_ARDY) | (1 << EV_STOP));
    // flags that a vector read must not retire
    localparam ev_vec_t VEC_KEEP = ev_vec_t'((1 << EV_RXRDY) | (1 << EV_TXRDY));

endpackage

// File: rtl/i2cev_flag_bank.sv
module i2cev_flag_bank
    import i2cev_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ev_vec_t set_pulse,
    input  ev_vec_t clr_req,
    output ev_vec_t flags
);

    for (genvar i = 0; i < EV_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (set_pulse[i])
                flags[i] <= 1'b1;
            else if (clr_req[i])
                flags[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/i2cev_prio.sv
module i2cev_prio
    import i2cev_pkg::*;
(
    input  ev_vec_t pend,
    output ev_vec_t sel_onehot,
    output code_t   code
);

    ev_vec_t seen;

    assign seen[0] = 1'b0;
    for (genvar i = 1; i < EV_N; i++) begin : g_chain
        assign seen[i] = seen[i-1] | pend[i-1];
    end

    for (genvar i = 0; i < EV_N; i++) begin : g_pick
        assign sel_onehot[i] = pend[i] & ~seen[i];
    end

    always_comb begin
        code = '0;
        for (int i = 0; i < EV_N; i++) begin
            if (sel_onehot[i])
                code = code | idx_to_code(i);
        end
    end

endmodule

// File: rtl/i2cev_regif.sv
module i2cev_regif
    import i2cev_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    reg_wr,
    input  logic    reg_rd,
    input  addr_t   reg_addr,
    input  word_t   reg_wdata,
    input  ev_vec_t flags,
    input  code_t   code,
    input  logic    rx_full,
    input  logic    bus_busy,
    output access_t acc,
    output ev_vec_t mask,
    output word_t   rdata
);

    rsel_t rsel;
    word_t stat_word;
    word_t unused_wdata_hi;

    assign unused_wdata_hi = reg_wdata;

    always_comb begin
        acc         = '0;
        acc.mask_wr = reg_wr && (reg_addr == OFS_MASK);
        acc.stat_wr = reg_wr && (reg_addr == OFS_STAT);
        acc.txd_wr  = reg_wr && (reg_addr == OFS_TXD);
        acc.vec_rd  = reg_rd && (reg_addr == OFS_VEC);
        acc.rxd_rd  = reg_rd && (reg_addr == OFS_RXD);
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask <= '0;
        else if (acc.mask_wr)
            mask <= reg_wdata[EV_N-1:0];
    end

    always_comb begin
        stat_word             = '0;
        stat_word[EV_N-1:0]   = flags;
        stat_word[BIT_RXFULL] = rx_full;
        stat_word[BIT_BUSY]   = bus_busy;
    end

    always_comb begin
        rsel = RSEL_NONE;
        if (reg_rd) begin
            case (reg_addr)
                OFS_MASK: rsel = RSEL_MASK;
                OFS_STAT: rsel = RSEL_STAT;
                OFS_VEC:  rsel = RSEL_VEC;
                default:  rsel = RSEL_NONE;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (rsel)
            RSEL_MASK: rdata[EV_N-1:0]   = mask;
            RSEL_STAT: rdata             = stat_word;
            RSEL_VEC:  rdata[CODE_W-1:0] = code;
            default:   rdata             = '0;
        endcase
    end

endmodule

// File: rtl/i2c_event_intc.sv
module i2c_event_intc
    import i2cev_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [EV_N-1:0]   ev_set,
    input  logic              rx_full_in,
    input  logic              bus_busy_in,
    output logic              irq
);

    access_t acc;
    ev_vec_t mask_q;
    ev_vec_t flags_q;
    ev_vec_t pend;
    ev_vec_t sel_onehot;
    ev_vec_t clr_req;
    code_t   vec_code;
    logic    irq_q;

    i2cev_regif u_regif (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .flags     (flags_q),
        .code      (vec_code),
        .rx_full   (rx_full_in),
        .bus_busy  (bus_busy_in),
        .acc       (acc),
        .mask      (mask_q),
        .rdata     (reg_rdata)
    );

    assign pend = flags_q & mask_q;

    i2cev_prio u_prio (
        .pend       (pend),
        .sel_onehot (sel_onehot),
        .code       (vec_code)
    );

    always_comb begin
        clr_req = '0;
        if (acc.stat_wr)
            clr_req = clr_req | (reg_wdata[EV_N-1:0] & W1C_SEL);
        if (acc.vec_rd)
            clr_req = clr_req | (sel_onehot & ~VEC_KEEP);
        if (acc.rxd_rd)
            clr_req = clr_req | bit_of(EV_RXRDY);
        if (acc.txd_wr)
            clr_req = clr_req | bit_of(EV_TXRDY);
    end

    i2cev_flag_bank u_flags (
        .clk       (clk),
        .rst       (rst),
        .set_pulse (ev_set),
        .clr_req   (clr_req),
        .flags     (flags_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= |pend;
    end

    assign irq = irq_q;

endmodule

// File: rtl/i2cev_chk.sv
module i2cev_chk
    import i2cev_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input ev_vec_t ev_set,
    input ev_vec_t flags,
    input ev_vec_t mask,
    input code_t   code,
    input logic    vec_rd,
    input logic    rxd_rd,
    input logic    stat_wr,
    input logic    wd_ardy,
    input logic    irq
);

    // R9
    irq_lag_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq == $past(|(flags & mask))));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|ev_set) |=> ((flags & $past(ev_set)) == $past(ev_set)));

    // R4
    vec_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (code == '0) == ((flags & mask) == '0));

    // R6
    rx_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_rd && code == code_t'(4) && !rxd_rd) |=> flags[EV_RXRDY]);

    // R7
    w1c_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !wd_ardy && flags[EV_ARDY]) |=> flags[EV_ARDY]);

    // R5
    vec_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_rd && code == code_t'(1) && !ev_set[EV_ARB]) |=> !flags[EV_ARB]);

endmodule

bind i2c_event_intc i2cev_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ev_set  (ev_set),
    .flags   (flags_q),
    .mask    (mask_q),
    .code    (vec_code),
    .vec_rd  (acc.vec_rd),
    .rxd_rd  (acc.rxd_rd),
    .stat_wr (acc.stat_wr),
    .wd_ardy (reg_wdata[2]),
    .irq     (irq)
);

// File: tb/tb_i2c_event_intc.sv
`timescale 1ns/1ps
module tb_i2c_event_intc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [6:0]  ev_set = '0;
    logic        rx_full_in = 1'b0;
    logic        bus_busy_in = 1'b0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // reference state
    bit [6:0] m_flags = '0;
    bit [6:0] m_mask  = '0;
    bit       m_irq   = 1'b0;

    always #2.5 clk = ~clk;

    i2c_event_intc dut (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .ev_set      (ev_set),
        .rx_full_in  (rx_full_in),
        .bus_busy_in (bus_busy_in),
        .irq         (irq)
    );

    function automatic int m_vec();
        for (int i = 0; i < 7; i++)
            if (m_flags[i] && m_mask[i]) return i + 1;
        return 0;
    endfunction

    function automatic logic [15:0] m_read(input logic [5:0] a);
        case (a)
            6'h04: return {9'b0, m_mask};
            6'h08: return {3'b0, bus_busy_in, rx_full_in, 4'b0, m_flags};
            6'h28: return 16'(m_vec());
            default: return 16'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(input bit wr, input bit rd, input logic [5:0] a,
                              input logic [15:0] wd, input logic [6:0] st);
        bit [6:0] clr;
        int v;
        clr = '0;
        m_irq = |(m_flags & m_mask);
        if (wr && a == 6'h08) begin
            if (wd[2]) clr[2] = 1;
            if (wd[5]) clr[5] = 1;
        end
        if (rd && a == 6'h28) begin
            v = m_vec();
            if (v != 0 && v != 4 && v != 5) clr[v-1] = 1;
        end
        if (rd && a == 6'h18) clr[3] = 1;
        if (wr && a == 6'h20) clr[4] = 1;
        m_flags = (m_flags & ~clr) | st;
        if (wr && a == 6'h04) m_mask = wd[6:0];
    endtask

    task automatic cyc(input bit wr, input bit rd, input logic [5:0] a,
                       input logic [15:0] wd, input logic [6:0] st, input string tag);
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd; ev_set = st;
        #1;
        check("R9 irq", {15'b0, irq}, {15'b0, m_irq});
        if (rd) check(tag, reg_rdata, m_read(a));
        @(posedge clk);
        model_step(wr, rd, a, wd, st);
    endtask

    task automatic idle();
        cyc(0, 0, 6'h00, 16'h0, 7'h0, "");
    endtask

    task automatic rd_reg(input logic [5:0] a, input string tag);
        cyc(0, 1, a, 16'h0, 7'h0, tag);
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [15:0] d, input string tag);
        cyc(1, 0, a, d, 7'h0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_reg(6'h04, "R1 mask reset");
        rd_reg(6'h08, "R1 status reset");
        rd_reg(6'h28, "R1 vector reset");

        // R2 set pulses with mask off; R4 disabled events invisible
        cyc(0, 0, 6'h00, 16'h0, 7'h7F, "R2");
        rx_full_in = 1'b1; bus_busy_in = 1'b1;
        rd_reg(6'h08, "R2 status all set");
        rd_reg(6'h28, "R4 masked vector zero");
        idle();
        // R3 mask write/readback, upper bits ignored
        wr_reg(6'h04, 16'hFF7F, "R3");
        rd_reg(6'h04, "R3 mask readback");
        idle();
        // R4/R5/R6 vector walk
        rd_reg(6'h28, "R5 vector arb");
        rd_reg(6'h28, "R5 vector nack");
        rd_reg(6'h28, "R5 vector ardy");
        rd_reg(6'h28, "R6 vector rx");
        rd_reg(6'h28, "R6 vector rx again");
        rd_reg(6'h18, "R6 rx data read");
        rd_reg(6'h28, "R6 vector tx");
        rd_reg(6'h28, "R6 vector tx again");
        wr_reg(6'h20, 16'h00A5, "R6 tx write");
        rd_reg(6'h28, "R5 vector stop");
        rd_reg(6'h28, "R5 vector slave");
        rd_reg(6'h28, "R4 vector empty");
        rd_reg(6'h08, "R2 status empty");

        // R7 write-one-clear
        rx_full_in = 1'b0;
        cyc(0, 0, 6'h00, 16'h0, 7'h27, "R7");
        wr_reg(6'h08, 16'h0000, "R7 zero write");
        rd_reg(6'h08, "R7 unchanged");
        wr_reg(6'h08, 16'hFFDB, "R7 other ones ignored");
        rd_reg(6'h08, "R7 others kept");
        wr_reg(6'h08, 16'h0024, "R7 clear ardy stop");
        rd_reg(6'h08, "R7 cleared");

        // R8 set beats clear
        cyc(0, 0, 6'h00, 16'h0, 7'h04, "R8");
        cyc(1, 0, 6'h08, 16'h0004, 7'h04, "R8");
        rd_reg(6'h08, "R8 set over w1c");
        cyc(0, 0, 6'h00, 16'h0, 7'h01, "R8");
        cyc(0, 1, 6'h28, 16'h0, 7'h01, "R8 vector read with set");
        rd_reg(6'h28, "R8 flag survives");

        // R10 unmapped offsets
        rd_reg(6'h30, "R10 unmapped read");
        rd_reg(6'h20, "R10 tx offset read");
        wr_reg(6'h10, 16'hFFFF, "R10 unmapped write");
        wr_reg(6'h28, 16'hFFFF, "R10 vector write");
        rd_reg(6'h04, "R10 mask intact");
        rd_reg(6'h08, "R10 status intact");

        // R9 irq with partial mask
        wr_reg(6'h04, 16'h0010, "R9");
        idle();
        cyc(0, 0, 6'h00, 16'h0, 7'h10, "R9");
        idle();
        idle();
        wr_reg(6'h20, 16'h0, "R9 tx clear");
        idle();
        idle();

        // mixed stimulus
        lfsr = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            logic [2:0] op;
            logic [6:0] st;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            op = lfsr[2:0];
            st = (lfsr[3] && lfsr[4]) ? lfsr[11:5] : 7'h0;
            rx_full_in = lfsr[12];
            bus_busy_in = lfsr[14];
            case (op)
                3'd0: cyc(0, 0, 6'h00, 16'h0, st, "R2 mix");
                3'd1: cyc(1, 0, 6'h04, lfsr, st, "R3 mix");
                3'd2: cyc(1, 0, 6'h08, lfsr, st, "R7 mix");
                3'd3: cyc(0, 1, 6'h28, 16'h0, st, "R4 mix");
                3'd4: cyc(0, 1, 6'h08, 16'h0, st, "R2 mix");
                3'd5: cyc(0, 1, 6'h18, 16'h0, st, "R6 mix");
                3'd6: cyc(1, 0, 6'h20, lfsr, st, "R6 mix");
                default: cyc(0, 1, 6'h28, 16'h0, st, "R5 mix");
            endcase
        end
        idle();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule